// File: doc/BRIEF.md
# Interrupt Acknowledge Wait Sequencer

This block sits between a CPU bus and a peripheral that returns an interrupt vector when it is acknowledged. It sees an acknowledge cycle one clock early: on the first rising clock edge at which the CPU's opcode-fetch strobe (M1) is seen low, the memory-request strobe must be high. A normal opcode fetch has its memory request already active at that edge and is not taken for an acknowledge.

Once an acknowledge is found, the block drives the peripheral's acknowledge strobe low at once and holds the CPU in a wait state. It then pulls the peripheral read strobe low a fixed number of clocks later. That delay lets the interrupt daisy chain settle before the vector is driven onto the bus. The delay comes from a tap on a shift register clocked by the CPU clock, and the parameter `TAP` selects the tap, so each step adds one whole clock.

Outside acknowledge cycles the block passes the system read and write strobes to the peripheral, gated by the peripheral select. All pins are plain level strobes. There is no data stream and no valid/ready handshake.

Top module: `iack_wait_seq`

## Requirements
- R1: While reset is held, with M1 high, RD and WR high and the select high, all four outputs are high.
- R2: While M1 is high, `ack_n` and `cpu_wait_n` stay high for every combination of MREQ, RD, WR and select.
- R3: If MREQ is low at the first edge where M1 is seen low (an opcode fetch), no acknowledge is started. None is started later in the same M1 period either, even if MREQ then goes high.
- R4: If the first edge where M1 is seen low has MREQ high, `ack_n` goes low after that edge. It stays low while M1 stays low.
- R5: `cpu_wait_n` goes low together with `ack_n` and stays low for exactly `TAP` clocks.
- R6: During an acknowledge, `per_rd_n` goes low after the `TAP`-th clock edge following the edge that asserted `ack_n`. This is the same edge on which `cpu_wait_n` returns high. It does not depend on RD or the select.
- R7: When M1 returns high, `ack_n`, `cpu_wait_n` and the acknowledge read return high at once, without waiting for a clock. The sequence is cleared, so a later acknowledge restarts from its first step.
- R8: Outside an acknowledge, `per_rd_n` is low exactly when RD and the select are both low. `per_wr_n` is low exactly when WR and the select are both low.
- R9: `per_wr_n` is never low while `ack_n` is low, whatever the state of WR and the select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| m1_n | input | 1 | CPU opcode-fetch strobe, active low |
| mreq_n | input | 1 | CPU memory-request strobe, active low |
| rd_n | input | 1 | CPU read strobe, active low |
| wr_n | input | 1 | CPU write strobe, active low |
| sel_n | input | 1 | Peripheral select, active low |
| ack_n | output | 1 | Interrupt-acknowledge strobe to the peripheral, active low |
| per_rd_n | output | 1 | Read strobe to the peripheral, active low |
| per_wr_n | output | 1 | Write strobe to the peripheral, active low |
| cpu_wait_n | output | 1 | Wait request to the CPU, active low |

## Verification
The assertions assume the bus inputs change only between clock edges and never on a rising edge. They also assume that, from reset release, M1 sits high before any cycle begins, so the first low sample of M1 marks the start of a real bus cycle. The bench changes every input on the falling clock edge and begins each cycle from M1 high. It returns M1 high for at least one full clock between cycles, so the one-cycle history that the detector and the checker rely on always matches a legal bus.

// File: rtl/iack_pkg.sv
package iack_pkg;

  // Bus strobes after conversion to active-high polarity.
  typedef struct packed {
    logic fetch;
    logic memreq;
    logic rd;
    logic wr;
    logic sel;
  } bus_req_t;

  // Peripheral-side and CPU-side strobes, active high.
  typedef struct packed {
    logic ack;
    logic prd;
    logic pwr;
    logic hold;
  } per_drv_t;

  function automatic bus_req_t to_active_high(input logic m1_n, input logic mreq_n,
                                              input logic rd_n, input logic wr_n,
                                              input logic sel_n);
    bus_req_t r;
    r.fetch  = ~m1_n;
    r.memreq = ~mreq_n;
    r.rd     = ~rd_n;
    r.wr     = ~wr_n;
    r.sel    = ~sel_n;
    return r;
  endfunction

endpackage

// File: rtl/iack_detect.sv
module iack_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic fetch,
  input  logic memreq,
  output logic start
);

  // High when M1 was already low at the previous edge; only the first
  // low sample of M1 may start an acknowledge.
  logic fetch_seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fetch_seen_q <= 1'b0;
    else        fetch_seen_q <= fetch;
  end

  assign start = fetch & ~memreq & ~fetch_seen_q;

endmodule

// File: rtl/iack_tapline.sv
module iack_tapline #(
  parameter int TAP = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         start,
  output logic [TAP:0] stage
);

  localparam int LAST = TAP;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      stage[0] <= 1'b0;
    else if (clr)    stage[0] <= 1'b0;
    else if (start)  stage[0] <= 1'b1;
  end

  for (genvar k = 1; k <= LAST; k++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    stage[k] <= 1'b0;
      else if (clr)  stage[k] <= 1'b0;
      else           stage[k] <= stage[k-1];
    end
  end

endmodule

// File: rtl/iack_strobe_map.sv
module iack_strobe_map
  import iack_pkg::*;
(
  input  bus_req_t bus,
  input  logic     in_ack,
  input  logic     ack_read,
  input  logic     ack_hold,
  output per_drv_t drv
);

  always_comb begin
    drv.ack  = in_ack;
    drv.hold = ack_hold;
    drv.prd  = ack_read | (~in_ack & bus.sel & bus.rd);
    drv.pwr  = ~in_ack & bus.sel & bus.wr;
  end

endmodule

// File: rtl/iack_wait_seq.sv
module iack_wait_seq
  import iack_pkg::*;
#(
  parameter int TAP = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic m1_n,
  input  logic mreq_n,
  input  logic rd_n,
  input  logic wr_n,
  input  logic sel_n,
  output logic ack_n,
  output logic per_rd_n,
  output logic per_wr_n,
  output logic cpu_wait_n
);

  localparam int STAGES = TAP + 1;

  bus_req_t          bus;
  logic              start;
  logic [STAGES-1:0] stage;
  logic              in_ack;
  logic              ack_read;
  logic              ack_hold;
  per_drv_t          drv;

  assign bus = to_active_high(m1_n, mreq_n, rd_n, wr_n, sel_n);

  iack_detect u_detect (
    .clk    (clk),
    .rst_n  (rst_n),
    .fetch  (bus.fetch),
    .memreq (bus.memreq),
    .start  (start)
  );

  iack_tapline #(.TAP(TAP)) u_tapline (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (~bus.fetch),
    .start (start),
    .stage (stage)
  );

  // Gated by M1 so every acknowledge output drops the moment M1 rises.
  assign in_ack   = stage[0] & bus.fetch;
  assign ack_read = stage[TAP] & bus.fetch;
  assign ack_hold = in_ack & ~stage[TAP];

  iack_strobe_map u_map (
    .bus      (bus),
    .in_ack   (in_ack),
    .ack_read (ack_read),
    .ack_hold (ack_hold),
    .drv      (drv)
  );

  assign ack_n      = ~drv.ack;
  assign per_rd_n   = ~drv.prd;
  assign per_wr_n   = ~drv.pwr;
  assign cpu_wait_n = ~drv.hold;

endmodule

// File: rtl/iack_wait_seq_chk.sv
module iack_wait_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic m1_n,
  input logic mreq_n,
  input logic ack_n,
  input logic per_rd_n,
  input logic per_wr_n,
  input logic cpu_wait_n
);

  // R9
  write_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_n |-> per_wr_n);

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m1_n |-> (ack_n && cpu_wait_n));

  // R4
  ack_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_n && $past(ack_n)) |-> $past(!m1_n && mreq_n));

  // R5
  wait_or_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_n |-> (cpu_wait_n != per_rd_n));

  // R6
  release_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cpu_wait_n) && !m1_n) |-> !per_rd_n);

endmodule

bind iack_wait_seq iack_wait_seq_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .m1_n       (m1_n),
  .mreq_n     (mreq_n),
  .ack_n      (ack_n),
  .per_rd_n   (per_rd_n),
  .per_wr_n   (per_wr_n),
  .cpu_wait_n (cpu_wait_n)
);

// File: tb/test_iack_wait_seq.sv
module test_iack_wait_seq;

  localparam int TAP = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m1_n = 1'b1, mreq_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, sel_n = 1'b1;
  logic ack_n, per_rd_n, per_wr_n, cpu_wait_n;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  iack_wait_seq #(.TAP(TAP)) i_iack_wait_seq (
    .clk(clk), .rst_n(rst_n), .m1_n(m1_n), .mreq_n(mreq_n), .rd_n(rd_n),
    .wr_n(wr_n), .sel_n(sel_n), .ack_n(ack_n), .per_rd_n(per_rd_n),
    .per_wr_n(per_wr_n), .cpu_wait_n(cpu_wait_n)
  );

  task automatic chk(input string req, input string what, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b", req, what, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #5;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual expired expected finished");
    finish_run();
  end

  initial begin
    // R1: reset state
    tick();
    tick();
    chk("R1", "ack_n", ack_n, 1'b1);
    chk("R1", "per_rd_n", per_rd_n, 1'b1);
    chk("R1", "per_wr_n", per_wr_n, 1'b1);
    chk("R1", "cpu_wait_n", cpu_wait_n, 1'b1);
    @(negedge clk) rst_n = 1'b1;
    tick();

    // R2, R8: sweep all strobe combinations with M1 high
    for (int v = 0; v < 16; v++) begin
      @(negedge clk);
      m1_n = 1'b1;
      mreq_n = v[0]; rd_n = v[1]; wr_n = v[2]; sel_n = v[3];
      tick();
      chk("R2", "ack_n", ack_n, 1'b1);
      chk("R2", "cpu_wait_n", cpu_wait_n, 1'b1);
      chk("R8", "per_rd_n", per_rd_n, ~(~v[1] & ~v[3]));
      chk("R8", "per_wr_n", per_wr_n, ~(~v[2] & ~v[3]));
    end

    // R3: opcode fetch, then MREQ released while M1 still low
    @(negedge clk);
    m1_n = 1'b0; mreq_n = 1'b0; rd_n = 1'b0; wr_n = 1'b1; sel_n = 1'b1;
    tick();
    chk("R3", "ack_n fetch", ack_n, 1'b1);
    chk("R3", "cpu_wait_n fetch", cpu_wait_n, 1'b1);
    @(negedge clk);
    mreq_n = 1'b1; rd_n = 1'b1;
    for (int j = 0; j < TAP + 2; j++) begin
      tick();
      chk("R3", "ack_n late", ack_n, 1'b1);
      chk("R3", "per_rd_n late", per_rd_n, 1'b1);
    end
    @(negedge clk) m1_n = 1'b1;
    tick();

    // R4..R7, R9: acknowledge cycles of several lengths
    for (int h = 1; h <= 7; h++) begin
      @(negedge clk);
      m1_n = 1'b0; mreq_n = 1'b1; rd_n = 1'b1;
      wr_n = h[0]; sel_n = h[1];
      #1;
      chk("R4", "ack_n before edge", ack_n, 1'b1);
      for (int j = 0; j < h; j++) begin
        tick();
        chk("R4", "ack_n", ack_n, 1'b0);
        chk("R5", "cpu_wait_n", cpu_wait_n, (j < TAP) ? 1'b0 : 1'b1);
        chk("R6", "per_rd_n", per_rd_n, (j >= TAP) ? 1'b0 : 1'b1);
        chk("R9", "per_wr_n", per_wr_n, 1'b1);
      end
      @(negedge clk);
      m1_n = 1'b1; wr_n = 1'b1; sel_n = 1'b1;
      #1;
      chk("R7", "ack_n release", ack_n, 1'b1);
      chk("R7", "cpu_wait_n release", cpu_wait_n, 1'b1);
      chk("R7", "per_rd_n release", per_rd_n, 1'b1);
      tick();
      chk("R7", "ack_n cleared", ack_n, 1'b1);
    end

    // R7: back-to-back acknowledge restarts the full delay
    @(negedge clk);
    m1_n = 1'b0; mreq_n = 1'b1;
    tick();
    chk("R7", "restart wait", cpu_wait_n, 1'b0);
    chk("R7", "restart read", per_rd_n, 1'b1);
    @(negedge clk) m1_n = 1'b1;
    tick();

    finish_run();
  end

endmodule